// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose write side and read side each run on their own clock. The two clocks can be unrelated, or one clock can drive both. By default the buffer holds 512 words of 9 bits. It reports four status flags. Two of them, empty and full, mark the ends of the buffer. The other two, almost-empty and almost-full, assert at fill levels set by offsets that software can program. Write and read pointers cross between the clock domains as Gray code through two-flop synchronizers. Full and almost-full are produced in the write domain. Empty and almost-empty are produced in the read domain.

The write side has two enables: an active-low primary enable and an active-high auxiliary enable, and a word is stored only when both are active. The level of the auxiliary enable during reset selects the write-side mode. If it is high, the buffer runs in plain mode. If it is held low, the buffer runs in load mode. In load mode, driving the auxiliary enable low strobes offset bytes in and out through the ordinary data ports. The read side pops a word only when both of its active-low enables are low. A separate active-low output enable gates the data output to zero.

Top module: `prog_flag_fifo`

## Requirements
- R1: A word is stored on a rising `wr_clk` when `wr_en_n` is 0 and `wr_aux` is 1. Words come out on `rd_data` in the order they were written, with one word loaded per accepted read on the rising `rd_clk`.
- R2: A read happens only when `rd_en_a_n` and `rd_en_b_n` are both 0. With only one of them low, nothing is popped and `rd_data` keeps its value.
- R3: When `rd_oe_n` is 1, `rd_data` is all zeros. When `rd_oe_n` is 0, `rd_data` shows the last word loaded into the output register.
- R4: After reset, with `rd_oe_n` low, `rd_data` is 0, `empty` and `almost_empty` are 1, and `full` and `almost_full` are 0.
- R5: Once the pointer synchronizers settle, `empty` is 1 exactly when no words are unread, and `full` is 1 exactly when 2^AW words are unread.
- R6: Once settled, `almost_full` is 1 exactly when the unread count is at least 2^AW minus the full offset. `almost_empty` is 1 exactly when the unread count is at most the empty offset. Each reset sets both offsets to 7.
- R7: A write attempted while `full` is 1 is dropped, and a read attempted while `empty` is 1 is dropped. Neither moves a pointer or changes `rd_data`.
- R8: If `wr_aux` is 0 while reset is applied, the block enters load mode. In load mode, each write cycle with `wr_en_n`=0 and `wr_aux`=0 stores `wr_data[7:0]` into the next offset byte. The bytes rotate in this order: empty-offset low, empty-offset high, full-offset low, full-offset high, then back to the start. Bit 0 of a high byte becomes offset bit 8. In plain mode the same enable pattern does nothing.
- R9: In load mode, a read cycle with both read enables at 0 and `wr_aux` at 0 places the next offset byte on `rd_data` as {0, byte}, following the same rotation. It pops no FIFO word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en_n | input | 1 | Primary write enable, active low |
| wr_aux | input | 1 | Second write enable (active high); in load mode, low strobes offset access |
| wr_data | input | DW | Write data; bits 7:0 carry offset bytes |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| rd_oe_n | input | 1 | Output enable, active low; high forces `rd_data` to zero |
| rd_data | output | DW | Registered read data |
| empty | output | 1 | No unread words (read domain) |
| full | output | 1 | All locations hold unread words (write domain) |
| almost_empty | output | 1 | Unread count at or below the empty offset (read domain) |
| almost_full | output | 1 | Unread count at or above depth minus the full offset (write domain) |

## Verification
The bench fills the whole 512-word buffer one word at a time and then drains it. After every step it compares all four flags with counts it works out itself. It does this once with the default offsets and once with offsets whose ninth bit is set. If a design had an off-by-one at a threshold, or ignored bit 8 of an offset, the flag would flip one level early or late, or would miss the threshold entirely.

Both overflow and underflow are attempted. A design that lets a write through when full would push a stray word into the drained sequence. A design that lets a read through when empty would change the held output.

Load-mode access is checked through the rotation, including wrap-around on both the load pointer and the readback pointer. A design that popped the FIFO during a readback would drop `full` and shift the data that comes out next.

// File: rtl/pff_pkg.sv
package pff_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] DEF_OFS = 8'd7;

  // Offset byte slots; the numbering is the access rotation order
  typedef enum logic [1:0] {
    OFS_AE_LO = 2'd0,
    OFS_AE_HI = 2'd1,
    OFS_AF_LO = 2'd2,
    OFS_AF_HI = 2'd3
  } ofs_sel_e;
endpackage

// File: rtl/pff_sync.sv
module pff_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/pff_offsets.sv
module pff_offsets
  import pff_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              ld_wr,
  input  logic [BYTE_W-1:0] ld_byte,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              ld_rd,
  output logic [BYTE_W-1:0] rb_byte,
  output logic [AW-1:0]     ae_ofs,
  output logic [AW-1:0]     af_ofs
);
  logic [3:0][BYTE_W-1:0] ofs_q, ofs_d;
  logic [1:0]             wsel_q, wsel_d;
  logic [1:0]             rsel_q, rsel_d;

  always_comb begin
    ofs_d  = ofs_q;
    wsel_d = wsel_q;
    if (ld_wr) begin
      ofs_d[wsel_q] = ld_byte;
      wsel_d        = wsel_q + 2'd1;
    end
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      ofs_q            <= '0;
      ofs_q[OFS_AE_LO] <= DEF_OFS;
      ofs_q[OFS_AF_LO] <= DEF_OFS;
      wsel_q           <= '0;
    end else begin
      ofs_q  <= ofs_d;
      wsel_q <= wsel_d;
    end
  end

  always_comb begin
    rsel_d = rsel_q;
    if (ld_rd) rsel_d = rsel_q + 2'd1;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rsel_q <= '0;
    else           rsel_q <= rsel_d;
  end

  // Offsets change only while idle; the read domain samples them quasi-statically
  assign rb_byte = ofs_q[rsel_q];
  assign ae_ofs  = AW'({ofs_q[OFS_AE_HI], ofs_q[OFS_AE_LO]});
  assign af_ofs  = AW'({ofs_q[OFS_AF_HI], ofs_q[OFS_AF_LO]});

  // R8
  ofs_hold_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !ld_wr |=> $stable(ofs_q));
endmodule

// File: rtl/pff_wr_side.sv
module pff_wr_side #(
  parameter int AW = 9
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          push_req,
  input  logic [AW:0]   rd_gray_s,
  input  logic [AW-1:0] af_ofs,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wr_gray,
  output logic          full,
  output logic          almost_full
);
  localparam int          DEPTH   = 1 << AW;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  logic [AW:0] wbin_q, wbin_d;
  logic [AW:0] wgray_q, wgray_d;
  logic [AW:0] rd_bin_s;
  logic [AW:0] level_d;
  logic        full_q, full_d;
  logic        af_q, af_d;

  always_comb begin
    rd_bin_s[AW] = rd_gray_s[AW];
    for (int i = AW - 1; i >= 0; i--) rd_bin_s[i] = rd_bin_s[i+1] ^ rd_gray_s[i];
  end

  assign wr_fire = push_req & ~full_q;

  always_comb begin
    wbin_d  = wbin_q + {{AW{1'b0}}, wr_fire};
    wgray_d = wbin_d ^ (wbin_d >> 1);
    level_d = wbin_d - rd_bin_s;
    full_d  = (level_d == DEPTH_V);
    af_d    = (level_d >= (DEPTH_V - {1'b0, af_ofs}));
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      af_q    <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      full_q  <= full_d;
      af_q    <= af_d;
    end
  end

  assign waddr       = wbin_q[AW-1:0];
  assign wr_gray     = wgray_q;
  assign full        = full_q;
  assign almost_full = af_q;

  // R7
  wr_hold_on_full_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (push_req && full_q) |=> $stable(wbin_q));
  // R6
  af_covers_full_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    full_q |-> af_q);
  // R5
  wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/pff_rd_side.sv
module pff_rd_side #(
  parameter int AW = 9
) (
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          pop_req,
  input  logic [AW:0]   wr_gray_s,
  input  logic [AW-1:0] ae_ofs,
  output logic          rd_fire,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rd_gray,
  output logic          empty,
  output logic          almost_empty
);
  logic [AW:0] rbin_q, rbin_d;
  logic [AW:0] rgray_q, rgray_d;
  logic [AW:0] wr_bin_s;
  logic [AW:0] level_d;
  logic        empty_q, empty_d;
  logic        ae_q, ae_d;

  always_comb begin
    wr_bin_s[AW] = wr_gray_s[AW];
    for (int i = AW - 1; i >= 0; i--) wr_bin_s[i] = wr_bin_s[i+1] ^ wr_gray_s[i];
  end

  assign rd_fire = pop_req & ~empty_q;

  always_comb begin
    rbin_d  = rbin_q + {{AW{1'b0}}, rd_fire};
    rgray_d = rbin_d ^ (rbin_d >> 1);
    level_d = wr_bin_s - rbin_d;
    empty_d = (level_d == '0);
    ae_d    = (level_d <= {1'b0, ae_ofs});
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_q <= 1'b1;
      ae_q    <= 1'b1;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      empty_q <= empty_d;
      ae_q    <= ae_d;
    end
  end

  assign raddr        = rbin_q[AW-1:0];
  assign rd_gray      = rgray_q;
  assign empty        = empty_q;
  assign almost_empty = ae_q;

  // R7
  rd_hold_on_empty_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (pop_req && empty_q) |=> $stable(rbin_q));
  // R6
  ae_covers_empty_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    empty_q |-> ae_q);
  // R9
  no_pop_idle_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !pop_req |=> $stable(rbin_q));
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
  import pff_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 9
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          wr_aux,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic          rd_oe_n,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int DEPTH = 1 << AW;

  logic              wr_rst_n, rd_rst_n;
  logic              load_mode_q;
  logic              push_req, ld_wr, pop_any, rb_sel, pop_req, ld_rd;
  logic              wr_fire, rd_fire;
  logic [AW-1:0]     waddr, raddr;
  logic [AW:0]       wr_gray, rd_gray, wr_gray_s, rd_gray_s;
  logic [AW-1:0]     ae_ofs, af_ofs;
  logic [BYTE_W-1:0] rb_byte;
  logic [DW-1:0]     mem_q [DEPTH];
  logic [DW-1:0]     rd_q, rd_d;

  pff_sync #(.W(1)) u_wr_rst (.clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wr_rst_n));
  pff_sync #(.W(1)) u_rd_rst (.clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rd_rst_n));

  // Mode is sampled on every write clock while the write domain is held in reset
  always_ff @(posedge wr_clk) begin
    if (!wr_rst_n) load_mode_q <= ~wr_aux;
  end

  assign push_req = ~wr_en_n & wr_aux;
  assign ld_wr    = load_mode_q & ~wr_en_n & ~wr_aux;
  assign pop_any  = ~rd_en_a_n & ~rd_en_b_n;
  assign rb_sel   = load_mode_q & ~wr_aux;
  assign pop_req  = pop_any & ~rb_sel;
  assign ld_rd    = pop_any & rb_sel;

  pff_sync #(.W(AW+1)) u_w2r (.clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s));
  pff_sync #(.W(AW+1)) u_r2w (.clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_s));

  pff_offsets #(.AW(AW)) u_ofs (
    .wr_clk  (wr_clk),
    .wr_rst_n(wr_rst_n),
    .ld_wr   (ld_wr),
    .ld_byte (BYTE_W'(wr_data)),
    .rd_clk  (rd_clk),
    .rd_rst_n(rd_rst_n),
    .ld_rd   (ld_rd),
    .rb_byte (rb_byte),
    .ae_ofs  (ae_ofs),
    .af_ofs  (af_ofs)
  );

  pff_wr_side #(.AW(AW)) u_wr (
    .wr_clk     (wr_clk),
    .wr_rst_n   (wr_rst_n),
    .push_req   (push_req),
    .rd_gray_s  (rd_gray_s),
    .af_ofs     (af_ofs),
    .wr_fire    (wr_fire),
    .waddr      (waddr),
    .wr_gray    (wr_gray),
    .full       (full),
    .almost_full(almost_full)
  );

  pff_rd_side #(.AW(AW)) u_rd (
    .rd_clk      (rd_clk),
    .rd_rst_n    (rd_rst_n),
    .pop_req     (pop_req),
    .wr_gray_s   (wr_gray_s),
    .ae_ofs      (ae_ofs),
    .rd_fire     (rd_fire),
    .raddr       (raddr),
    .rd_gray     (rd_gray),
    .empty       (empty),
    .almost_empty(almost_empty)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem_q[waddr] <= wr_data;
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_fire)    rd_d = mem_q[raddr];
    else if (ld_rd) rd_d = DW'(rb_byte);
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rd_q <= '0;
    else           rd_q <= rd_d;
  end

  assign rd_data = rd_oe_n ? '0 : rd_q;

  // R2
  out_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !pop_any |=> $stable(rd_q));
endmodule

// File: tb/prog_flag_fifo_tb.sv
module prog_flag_fifo_tb;
  localparam int AW    = 9;
  localparam int DW    = 9;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic rst_n, wr_en_n, wr_aux, rd_en_a_n, rd_en_b_n, rd_oe_n;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic empty, full, almost_empty, almost_full;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  prog_flag_fifo #(.AW(AW), .DW(DW)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en_n(wr_en_n), .wr_aux(wr_aux), .wr_data(wr_data),
    .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .rd_oe_n(rd_oe_n),
    .rd_data(rd_data), .empty(empty), .full(full),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  function automatic int pat(int i, int salt);
    return ((i * 37 + 5) % DEPTH) ^ salt;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic chk_flags(string tag, int lvl, int ae_off, int af_off);
    chk({tag, " R5 empty"},  int'(empty),        int'(lvl == 0));
    chk({tag, " R5 full"},   int'(full),         int'(lvl == DEPTH));
    chk({tag, " R6 a_empty"}, int'(almost_empty), int'(lvl <= ae_off));
    chk({tag, " R6 a_full"},  int'(almost_full),  int'(lvl >= DEPTH - af_off));
  endtask

  task automatic do_reset(logic aux);
    @(negedge wr_clk);
    rst_n = 1'b0; wr_aux = aux; wr_en_n = 1'b1;
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (5) @(negedge wr_clk);
    wr_aux = 1'b1;
    repeat (4) @(negedge rd_clk);
  endtask

  task automatic push(int d);
    @(negedge wr_clk);
    wr_en_n = 1'b0; wr_aux = 1'b1; wr_data = DW'(d);
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic load(int b);
    @(negedge wr_clk);
    wr_en_n = 1'b0; wr_aux = 1'b0; wr_data = DW'(b);
    @(negedge wr_clk);
    wr_en_n = 1'b1; wr_aux = 1'b1;
  endtask

  task automatic pop();
    @(negedge rd_clk);
    rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
    @(negedge rd_clk);
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
  endtask

  task automatic readback();
    @(negedge rd_clk);
    wr_aux = 1'b0; rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
    @(negedge rd_clk);
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1; wr_aux = 1'b1;
  endtask

  task automatic sweep(int salt, int ae_off, int af_off, string tag);
    for (int i = 0; i < DEPTH; i++) begin
      push(pat(i, salt));
      settle();
      chk_flags({tag, " fill"}, i + 1, ae_off, af_off);
    end
  endtask

  task automatic drain(int salt, int ae_off, int af_off, string tag);
    for (int i = 0; i < DEPTH; i++) begin
      pop();
      chk({tag, " R1 order"}, int'(rd_data), pat(i, salt));
      if (i == 100) begin
        rd_oe_n = 1'b1; #1;
        chk("R3 oe gate", int'(rd_data), 0);
        rd_oe_n = 1'b0; #1;
        chk("R3 oe pass", int'(rd_data), pat(i, salt));
      end
      settle();
      chk_flags({tag, " drain"}, DEPTH - 1 - i, ae_off, af_off);
    end
  endtask

  initial begin
    rst_n = 1'b0; wr_en_n = 1'b1; wr_aux = 1'b1; wr_data = '0;
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1; rd_oe_n = 1'b0;

    // Plain mode
    do_reset(1'b1);
    chk("R4 rd_data", int'(rd_data), 0);
    chk("R4 empty", int'(empty), 1);
    chk("R4 almost_empty", int'(almost_empty), 1);
    chk("R4 full", int'(full), 0);
    chk("R4 almost_full", int'(almost_full), 0);

    // R8: load pattern in plain mode stores nothing
    load(9'h0AA);
    settle();
    chk_flags("R8 plain ld", 0, 7, 7);

    sweep(0, 7, 7, "dflt");

    // R7: overflow attempt
    push(9'h155);
    settle();
    chk_flags("R7 overflow", DEPTH, 7, 7);

    // R2: single enable low pops nothing
    @(negedge rd_clk); rd_en_a_n = 1'b0;
    @(negedge rd_clk); rd_en_a_n = 1'b1; rd_en_b_n = 1'b0;
    @(negedge rd_clk); rd_en_b_n = 1'b1;
    settle();
    chk("R2 no pop data", int'(rd_data), 0);
    chk("R2 no pop full", int'(full), 1);

    drain(0, 7, 7, "dflt");

    // R7: underflow attempt keeps output
    pop();
    settle();
    chk("R7 underflow data", int'(rd_data), pat(DEPTH - 1, 0));
    chk("R7 underflow empty", int'(empty), 1);

    // Load mode
    do_reset(1'b0);
    chk("R4 rd_data load", int'(rd_data), 0);
    chk_flags("R4 load rst", 0, 7, 7);
    readback(); chk("R9 dflt ae lo", int'(rd_data), 7);
    readback(); chk("R9 dflt ae hi", int'(rd_data), 0);
    readback(); chk("R9 dflt af lo", int'(rd_data), 7);
    readback(); chk("R9 dflt af hi", int'(rd_data), 0);
    load(4); load(1); load(44); load(1);
    readback(); chk("R9 ae lo", int'(rd_data), 4);
    readback(); chk("R9 ae hi", int'(rd_data), 1);
    readback(); chk("R9 af lo", int'(rd_data), 44);
    readback(); chk("R9 af hi", int'(rd_data), 1);
    readback(); chk("R9 wrap", int'(rd_data), 4);
    load(2);  // R8: rotation wraps to empty-offset low byte, offset 258
    settle();
    chk("R9 rb no pop", int'(empty), 1);

    sweep(9'h0F0, 258, 300, "prog");

    readback();  // rotation now at empty-offset high byte
    chk("R9 rb at full", int'(rd_data), 1);
    settle();
    chk("R9 rb kept full", int'(full), 1);

    drain(9'h0F0, 258, 300, "prog");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge wr_clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule